// File: doc/BRIEF.md
# Length-Prefixed End-of-Packet Generator

This block sits at the root of a tree of stream routers. It receives a raw byte stream in which datagrams follow one another with nothing between them. Each datagram opens with a length value written as unsigned LEB128, and the rest of the datagram follows: route bytes, a zero delimiter, credit or management data and the payload. The block decodes the length, removes those bytes from the stream, and loads a single down-counter. It then passes the counted bytes through unchanged and flags the last of them with an end-of-packet marker. Routers further down can switch on that marker and need no counters of their own.

A parameter selects between two ways of treating the input end-of-packet flag. In flat mode an input flag closes the current datagram early. In nested mode the flag is ignored completely, so one counted datagram may span several outer fragments. Both sides use a valid/ready/data/last byte stream. Backpressure from the output stalls the counter.

Top module: `lpe_eop_gen`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: The length field is decoded 7 bits per byte, least significant group first. Bit 7 set means another length byte follows. The field is at most LEN_MAX_BYTES (default 5) bytes long. The byte in the last allowed position ends the field whatever its bit 7 is, and bits above CNT_W are discarded.
- R3: Length bytes are consumed and never forwarded. While a length field is being decoded, out_valid stays low and in_ready stays high.
- R4: After a length L, exactly the next L input bytes are forwarded unchanged and in order. out_last is high only on the L-th of them.
- R5: The input byte that follows the L-th forwarded byte is decoded as the first byte of a new length field.
- R6: A decoded length of zero, including a redundant multi-byte zero such as 0x80 0x00, produces no output beat. The next input byte starts a new length field.
- R7: While forwarding, in_ready equals out_ready. Only beats that complete a handshake are counted, so stalls neither drop nor repeat bytes.
- R8: With NESTED=0, an input byte that carries in_last during forwarding is forwarded with out_last set, and the datagram ends there. A length byte that carries in_last is dropped together with any partial length field.
- R9: With NESTED=1, in_last has no effect. out_last comes only from the count, and a datagram can continue across several input packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input end-of-packet flag |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream can take a byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output end-of-packet, on the last counted byte |

## Verification
Single-byte lengths, two- and five-byte lengths, and back-to-back datagrams show whether the decoder places each 7-bit group correctly and returns to length parsing at the right byte. Zero lengths, including a redundant two-byte zero, separate correct skipping from a stray output beat or a lost following byte. A 300-byte datagram checks that the counter carries past 8 bits. An output that alternates ready on every cycle shows whether stalls drop or repeat data. The same fragmented input is sent to a flat instance and to a nested instance, and the difference between early termination and pure counting appears at the ports.

// File: rtl/lpe_pkg.sv
package lpe_pkg;
  localparam int BYTE_W = 8;
  localparam int GRP_W  = 7;

  typedef enum logic [0:0] {
    ST_LEN  = 1'b0,
    ST_BODY = 1'b1
  } lpe_state_e;
endpackage

// File: rtl/lpe_rst_sync.sv
module lpe_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_out = stage2_q;
endmodule

// File: rtl/lpe_leb_decoder.sv
module lpe_leb_decoder import lpe_pkg::*; #(
  parameter int CNT_W     = 32,
  parameter int MAX_BYTES = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_en,
  input  logic              clear,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              done,
  output logic [CNT_W-1:0]  value
);
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0] placed;
  logic             final_byte;
  logic             upd_en;

  // place the current 7-bit group at its weight
  always_comb begin
    placed = '0;
    for (int g = 0; g < MAX_BYTES; g++) begin
      if (idx_q == IDX_W'(g)) begin
        placed = CNT_W'(byte_in[GRP_W-1:0]) << (GRP_W * g);
      end
    end
  end

  always_comb begin
    final_byte = !byte_in[BYTE_W-1] || (idx_q == IDX_W'(MAX_BYTES - 1));
    value      = acc_q | placed;
    done       = byte_en && final_byte;
    upd_en     = clear || byte_en;
    if (clear || done) begin
      acc_d = '0;
      idx_d = '0;
    end else begin
      acc_d = value;
      idx_d = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (upd_en) begin
      acc_q <= acc_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/lpe_beat_counter.sv
module lpe_beat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || dec;
    cnt_d  = load ? load_val : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/lpe_eop_gen.sv
module lpe_eop_gen import lpe_pkg::*; #(
  parameter int CNT_W         = 32,
  parameter int LEN_MAX_BYTES = 5,
  parameter bit NESTED        = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last
);
  logic             rst_n_s;
  lpe_state_e       state_q, state_d;
  logic             body;
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] len_val;
  logic             len_done;
  logic             hdr_take, hdr_abort, dec_en;
  logic             beat_fire, beat_term, cnt_last, cnt_load;
  logic             eop_honor;

  lpe_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  // mode select: nested mode never looks at the input boundary
  generate
    if (NESTED) begin : g_nested
      assign eop_honor = 1'b0;
    end else begin : g_flat
      assign eop_honor = in_last;
    end
  endgenerate

  always_comb begin
    body      = (state_q == ST_BODY);
    in_ready  = body ? out_ready : 1'b1;
    out_valid = body && in_valid;
    out_data  = in_data;
    cnt_last  = (rem_q == CNT_W'(1));
    beat_term = cnt_last || eop_honor;
    out_last  = body && beat_term;
    beat_fire = body && in_valid && out_ready;
    hdr_take  = !body && in_valid;
    hdr_abort = hdr_take && eop_honor;
    dec_en    = hdr_take && !hdr_abort;
    cnt_load  = len_done && (len_val != '0);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_LEN:  if (cnt_load) state_d = ST_BODY;
      ST_BODY: if (beat_fire && beat_term) state_d = ST_LEN;
      default: state_d = ST_LEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) state_q <= ST_LEN;
    else          state_q <= state_d;
  end

  lpe_leb_decoder #(
    .CNT_W     (CNT_W),
    .MAX_BYTES (LEN_MAX_BYTES)
  ) u_dec (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .byte_en (dec_en),
    .clear   (hdr_abort),
    .byte_in (in_data),
    .done    (len_done),
    .value   (len_val)
  );

  lpe_beat_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (cnt_load),
    .load_val (len_val),
    .dec      (beat_fire),
    .count    (rem_q)
  );
endmodule

// File: rtl/lpe_eop_gen_chk.sv
module lpe_eop_gen_chk #(
  parameter int CNT_W  = 32,
  parameter bit NESTED = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             body,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_last,
  input logic [CNT_W-1:0] rem
);
  // R3: length phase keeps output quiet and input open
  assert_len_phase_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !body |-> (in_ready && !out_valid));

  // R7: ready passes straight through while forwarding
  assert_ready_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    body |-> (in_ready == out_ready));

  // R4: each non-final handshake takes exactly one off the count
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (body && in_valid && out_ready && !out_last) |=> (body && (rem == $past(rem) - CNT_W'(1))));

  // R5: after a final beat the block is parsing a length again
  assert_back_to_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !body);

  // R6: a zero count never reaches the forwarding phase
  assert_no_zero_body_R6: assert property (@(posedge clk) disable iff (!rst_n)
    body |-> (rem != '0));

  generate
    if (NESTED) begin : g_nested_chk
      // R9: end-of-packet only from the count
      assert_count_only_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (rem == CNT_W'(1)));
    end
  endgenerate
endmodule

bind lpe_eop_gen lpe_eop_gen_chk #(
  .CNT_W  (CNT_W),
  .NESTED (NESTED)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .body      (body),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_last  (out_last),
  .rem       (rem_q)
);

// File: tb/tb_lpe_eop_gen.sv
module tb_lpe_eop_gen;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       in_valid, in_last, out_ready;
  logic [7:0] in_data;
  int         sel;

  logic       iv0, ir0, ov0, ol0;
  logic       iv1, ir1, ov1, ol1;
  logic [7:0] od0, od1;

  assign iv0 = in_valid && (sel == 0);
  assign iv1 = in_valid && (sel == 1);

  lpe_eop_gen #(.NESTED(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(iv0), .in_ready(ir0), .in_data(in_data),
    .in_last(in_last), .out_valid(ov0), .out_ready(out_ready), .out_data(od0), .out_last(ol0));

  lpe_eop_gen #(.NESTED(1'b1)) dut_nested (
    .clk(clk), .rst_n(rst_n), .in_valid(iv1), .in_ready(ir1), .in_data(in_data),
    .in_last(in_last), .out_valid(ov1), .out_ready(out_ready), .out_data(od1), .out_last(ol1));

  logic       c_ir, c_ov, c_ol;
  logic [7:0] c_od;
  assign c_ir = (sel == 0) ? ir0 : ir1;
  assign c_ov = (sel == 0) ? ov0 : ov1;
  assign c_ol = (sel == 0) ? ol0 : ol1;
  assign c_od = (sel == 0) ? od0 : od1;

  int total = 0, failed = 0;
  bit finished = 1'b0;
  logic [7:0] got_d [0:511];
  logic       got_l [0:511];
  logic [7:0] exp_d [0:511];
  logic       exp_l [0:511];
  int got_n, exp_n, hdr_viol, rdy_viol;
  bit is_hdr, stall;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic begin_case(input int which, input bit stl);
    sel = which; stall = stl; out_ready = 1'b1;
    got_n = 0; exp_n = 0; hdr_viol = 0; rdy_viol = 0;
  endtask

  task automatic want(input logic [7:0] d, input bit l);
    exp_d[exp_n] = d; exp_l[exp_n] = l; exp_n++;
  endtask

  // one cycle: sample just before the rising edge, then move to the falling edge
  task automatic step(output bit accepted);
    #4;
    if (c_ov && out_ready) begin
      got_d[got_n] = c_od; got_l[got_n] = c_ol; got_n++;
    end
    if (is_hdr && (c_ov || !c_ir)) hdr_viol++;
    if (!is_hdr && (c_ir != out_ready)) rdy_viol++;
    accepted = in_valid && c_ir;
    @(negedge clk);
    if (stall) out_ready = ~out_ready;
  endtask

  task automatic push(input logic [7:0] b, input bit l, input bit hdr);
    bit acc;
    in_data = b; in_last = l; in_valid = 1'b1; is_hdr = hdr;
    do step(acc); while (!acc);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic compare(input string req);
    int bad = 0;
    check(got_n == exp_n, req, "beat count", got_n, exp_n);
    for (int i = 0; i < got_n && i < exp_n; i++) begin
      if (got_d[i] !== exp_d[i] || got_l[i] !== exp_l[i]) begin
        bad++;
        $display("FAIL %s beat %0d: actual %0h/%0b expected %0h/%0b",
                 req, i, got_d[i], got_l[i], exp_d[i], exp_l[i]);
      end
    end
    total++;
    if (bad != 0) failed++;
    check(hdr_viol == 0, "R3", "length-phase violations", hdr_viol, 0);
  endtask

  task automatic t_reset();
    #4;
    check(ov0 == 1'b0 && ov1 == 1'b0, "R1", "out_valid after reset", ov0 | ov1, 0);
    check(ir0 == 1'b1 && ir1 == 1'b1, "R1", "in_ready after reset", ir0 & ir1, 1);
    @(negedge clk);
  endtask

  task automatic t_single();
    begin_case(0, 0);
    push(8'h03, 0, 1);
    push(8'hA1, 0, 0); push(8'hA2, 0, 0); push(8'hA3, 0, 0);
    want(8'hA1, 0); want(8'hA2, 0); want(8'hA3, 1);
    compare("R4");
  endtask

  task automatic t_two_byte_len();
    begin_case(0, 0);
    push(8'hAC, 0, 1); push(8'h02, 0, 1);   // 44 + 2*128 = 300
    for (int i = 0; i < 300; i++) begin
      push(8'(i), 0, 0);
      want(8'(i), i == 299);
    end
    compare("R2");
  endtask

  task automatic t_back_to_back();
    begin_case(0, 0);
    push(8'h02, 0, 1); push(8'h11, 0, 0); push(8'h22, 0, 0);
    push(8'h01, 0, 1); push(8'h33, 0, 0);
    want(8'h11, 0); want(8'h22, 1); want(8'h33, 1);
    compare("R5");
  endtask

  task automatic t_zero_len();
    begin_case(0, 0);
    push(8'h00, 0, 1);
    push(8'h80, 0, 1); push(8'h00, 0, 1);
    push(8'h02, 0, 1); push(8'h44, 0, 0); push(8'h55, 0, 0);
    want(8'h44, 0); want(8'h55, 1);
    compare("R6");
  endtask

  task automatic t_five_byte_len();
    begin_case(0, 0);
    // fifth byte has bit 7 set but still closes the field: value 1
    push(8'h81, 0, 1); push(8'h80, 0, 1); push(8'h80, 0, 1);
    push(8'h80, 0, 1); push(8'h80, 0, 1);
    push(8'h66, 0, 0);
    push(8'h01, 0, 1); push(8'h77, 0, 0);
    want(8'h66, 1); want(8'h77, 1);
    compare("R2");
  endtask

  task automatic t_backpressure();
    begin_case(0, 1);
    push(8'h05, 0, 1);
    for (int i = 0; i < 5; i++) begin
      push(8'hC0 + 8'(i), 0, 0);
      want(8'hC0 + 8'(i), i == 4);
    end
    compare("R7");
    check(rdy_viol == 0, "R7", "in_ready != out_ready cycles", rdy_viol, 0);
    stall = 0; out_ready = 1'b1;
  endtask

  task automatic t_flat_early_last();
    begin_case(0, 0);
    push(8'h04, 0, 1); push(8'hD1, 0, 0); push(8'hD2, 1, 0);
    push(8'h01, 0, 1); push(8'hD3, 0, 0);
    push(8'h85, 1, 1);                       // partial length dropped
    push(8'h02, 0, 1); push(8'hD4, 0, 0); push(8'hD5, 0, 0);
    want(8'hD1, 0); want(8'hD2, 1); want(8'hD3, 1); want(8'hD4, 0); want(8'hD5, 1);
    compare("R8");
  endtask

  task automatic t_nested();
    begin_case(1, 0);
    push(8'h05, 0, 1);
    push(8'hE1, 0, 0); push(8'hE2, 1, 0); push(8'hE3, 0, 0);
    push(8'hE4, 1, 0); push(8'hE5, 0, 0);
    push(8'h82, 1, 1); push(8'h00, 0, 1);    // length 2, flag ignored
    push(8'hE6, 1, 0); push(8'hE7, 0, 0);
    want(8'hE1, 0); want(8'hE2, 0); want(8'hE3, 0); want(8'hE4, 0); want(8'hE5, 1);
    want(8'hE6, 0); want(8'hE7, 1);
    compare("R9");
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    out_ready = 1'b1; sel = 0; is_hdr = 1'b1; stall = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_two_byte_len();
    t_back_to_back();
    t_zero_len();
    t_five_byte_len();
    t_backpressure();
    t_flat_early_last();
    t_nested();
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule